// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the data-hazard controller of a five-stage in-order pipeline with stages fetch, decode, execute, memory and write-back. Every cycle it takes the register indices read by the instruction in decode and by the instruction in execute. It compares them with the destination indices, write enables and load flag of the older instructions further down the pipe. From that it produces one bypass-multiplexer select per ALU operand, plus a stall request that holds the fetch address and the fetch/decode register and puts a no-op into execute.

An ALU result feeds the next instruction straight from the execute/memory register, so a dependent ALU pair runs back to back with no lost cycle. A loaded value only exists after the memory stage. A consumer right behind a load is therefore held in decode for exactly one cycle, and then takes the value from the memory/write-back register. The parameter `EARLY_SEL` chooses where the selects are formed. With 1 (the default) they are computed from the decode sources and registered into execute. With 0 they are computed combinationally from the execute sources. Both give the same selects at the ports when the block is driven by a pipeline that obeys its stall.

Top module: `hzd_fwd_unit`

## Requirements
- R1: `fwd_sel` holds one 2-bit field per operand, operand k at bits [2k+1:2k]; code 00 selects the register file, 10 the execute/memory result, 01 the memory/write-back result; code 11 never appears.
- R2: When a used execute-stage source equals the destination of the instruction in memory (write enable high, index non-zero), that operand's field is 10, so a dependent ALU pair needs no stall.
- R3: When a used execute-stage source matches only the instruction in write-back (write enable high, index non-zero), the field is 01.
- R4: When both older stages match the same source, the memory-stage (younger) result wins and the field is 10.
- R5: A destination index of 0, a low producer write enable or a source marked unused never causes forwarding or a stall.
- R6: When execute holds a load with write enable high and a non-zero destination equal to a used decode source, `hold_front` and `bubble_ex` are high in that same cycle.
- R7: A load-use stall lasts exactly one cycle in a pipeline that obeys it; in the following cycle no stall is raised, and once the consumer reaches execute it receives the loaded value with code 01.
- R8: A non-load producer in execute that matches a decode source never raises a stall.
- R9: `hold_front` and `bubble_ex` are always equal.
- R10: During reset and with an empty pipeline, every select field is 00 and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the registered select variant |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_idx | input | NSRC*RW | Source register indices of the decode instruction, operand k at [k*RW +: RW] |
| id_src_use | input | NSRC | Per-operand flag that the decode instruction reads that source |
| ex_src_idx | input | NSRC*RW | Source register indices of the execute instruction |
| ex_src_use | input | NSRC | Per-operand flag that the execute instruction reads that source |
| ex_dst_idx | input | RW | Destination index of the execute instruction |
| ex_dst_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst_idx | input | RW | Destination index of the memory-stage instruction |
| mem_dst_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst_idx | input | RW | Destination index of the write-back instruction |
| wb_dst_wen | input | 1 | Write-back instruction writes a register |
| fwd_sel | output | 2*NSRC | Bypass select per ALU operand |
| hold_front | output | 1 | Hold the fetch address and the fetch/decode register |
| bubble_ex | output | 1 | Load a no-op into the execute stage |

## Verification
The hardest case to reach is the cycle after a load-use stall. There the consumer must arrive in execute one cycle late and take the load value from write-back, which only happens if the stimulus itself honours the stall. The bench therefore models the pipeline as records moving stage to stage, freezing decode and inserting a no-op whenever its own model predicts a stall. Scripted load/consumer pairs, same-destination pairs and index-0 producers are followed by a long random stream over only four register indices, so matches in both older stages, on either operand, occur often.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_sel_e;

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
   parameter int RW = 5
) (
   input  logic [RW-1:0] src_idx,
   input  logic          src_use,
   input  logic [RW-1:0] dst_idx,
   input  logic          dst_wen,
   output logic          hit
);
   // index 0 is hardwired and never a real producer
   always_comb begin
      hit = src_use && dst_wen && (dst_idx != '0) && (src_idx == dst_idx);
   end
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
   import hzd_pkg::*;
(
   input  logic     hit_young,
   input  logic     hit_old,
   output fwd_sel_e sel
);
   always_comb begin
      if (hit_young)    sel = FWD_MEM;
      else if (hit_old) sel = FWD_WB;
      else              sel = FWD_RF;
   end
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
   parameter int RW   = 5,
   parameter int NSRC = 2
) (
   input  logic [NSRC*RW-1:0] id_src_idx,
   input  logic [NSRC-1:0]    id_src_use,
   input  logic [RW-1:0]      ex_dst_idx,
   input  logic               ex_dst_wen,
   input  logic               ex_is_load,
   output logic               stall
);
   logic [NSRC-1:0] dep;

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      hzd_match #(.RW(RW)) u_m (
         .src_idx (id_src_idx[k*RW +: RW]),
         .src_use (id_src_use[k]),
         .dst_idx (ex_dst_idx),
         .dst_wen (ex_dst_wen),
         .hit     (dep[k])
      );
   end

   always_comb begin
      stall = ex_is_load && (|dep);
   end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
   import hzd_pkg::*;
#(
   parameter int RW        = 5,
   parameter int NSRC      = 2,
   parameter bit EARLY_SEL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC*RW-1:0] id_src_idx,
   input  logic [NSRC-1:0]    id_src_use,
   input  logic [NSRC*RW-1:0] ex_src_idx,
   input  logic [NSRC-1:0]    ex_src_use,
   input  logic [RW-1:0]      ex_dst_idx,
   input  logic               ex_dst_wen,
   input  logic               ex_is_load,
   input  logic [RW-1:0]      mem_dst_idx,
   input  logic               mem_dst_wen,
   input  logic [RW-1:0]      wb_dst_idx,
   input  logic               wb_dst_wen,
   output logic [2*NSRC-1:0]  fwd_sel,
   output logic               hold_front,
   output logic               bubble_ex
);
   localparam int SEL_W = 2 * NSRC;

   if (RW < 1 || RW > 8) begin : g_bad_rw
      $error("hzd_fwd_unit: RW must lie in 1..8");
   end
   if (NSRC < 1 || NSRC > 4) begin : g_bad_nsrc
      $error("hzd_fwd_unit: NSRC must lie in 1..4");
   end

   logic stall;

   hzd_loaduse #(.RW(RW), .NSRC(NSRC)) u_lu (
      .id_src_idx (id_src_idx),
      .id_src_use (id_src_use),
      .ex_dst_idx (ex_dst_idx),
      .ex_dst_wen (ex_dst_wen),
      .ex_is_load (ex_is_load),
      .stall      (stall)
   );

   assign hold_front = stall;
   assign bubble_ex  = stall;

   if (EARLY_SEL) begin : g_early
      // decode sources against the producers that will sit one stage
      // further down once this instruction enters execute
      logic [SEL_W-1:0] sel_q;
      logic             unused_early;
      assign unused_early = ^{ex_src_idx, ex_src_use, wb_dst_idx, wb_dst_wen};

      for (genvar k = 0; k < NSRC; k++) begin : g_src
         logic     hit_y, hit_o;
         fwd_sel_e nxt;
         hzd_match #(.RW(RW)) u_my (
            .src_idx (id_src_idx[k*RW +: RW]),
            .src_use (id_src_use[k]),
            .dst_idx (ex_dst_idx),
            .dst_wen (ex_dst_wen),
            .hit     (hit_y)
         );
         hzd_match #(.RW(RW)) u_mo (
            .src_idx (id_src_idx[k*RW +: RW]),
            .src_use (id_src_use[k]),
            .dst_idx (mem_dst_idx),
            .dst_wen (mem_dst_wen),
            .hit     (hit_o)
         );
         hzd_fwd_pick u_pick (
            .hit_young (hit_y),
            .hit_old   (hit_o),
            .sel       (nxt)
         );
         always_ff @(posedge clk) begin
            if (!rst_n)     sel_q[2*k +: 2] <= FWD_RF;
            else if (stall) sel_q[2*k +: 2] <= FWD_RF;
            else            sel_q[2*k +: 2] <= nxt;
         end
      end
      assign fwd_sel = sel_q;
   end else begin : g_late
      logic unused_late;
      assign unused_late = ^{clk, rst_n};

      for (genvar k = 0; k < NSRC; k++) begin : g_src
         logic     hit_y, hit_o;
         fwd_sel_e sel;
         hzd_match #(.RW(RW)) u_my (
            .src_idx (ex_src_idx[k*RW +: RW]),
            .src_use (ex_src_use[k]),
            .dst_idx (mem_dst_idx),
            .dst_wen (mem_dst_wen),
            .hit     (hit_y)
         );
         hzd_match #(.RW(RW)) u_mo (
            .src_idx (ex_src_idx[k*RW +: RW]),
            .src_use (ex_src_use[k]),
            .dst_idx (wb_dst_idx),
            .dst_wen (wb_dst_wen),
            .hit     (hit_o)
         );
         hzd_fwd_pick u_pick (
            .hit_young (hit_y),
            .hit_old   (hit_o),
            .sel       (sel)
         );
         assign fwd_sel[2*k +: 2] = sel;
      end
   end
endmodule

// File: rtl/hzd_fwd_chk.sv
module hzd_fwd_chk #(
   parameter int RW   = 5,
   parameter int NSRC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [RW-1:0]     ex_src0,
   input logic              ex_use0,
   input logic [RW-1:0]     ex_dst_idx,
   input logic              ex_is_load,
   input logic [RW-1:0]     mem_dst_idx,
   input logic              mem_dst_wen,
   input logic [2*NSRC-1:0] fwd_sel,
   input logic              hold_front,
   input logic              bubble_ex
);
   localparam logic [2*NSRC-1:0] LOW_BITS = {NSRC{2'b01}};

   AST_HOLD_EQ_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_front == bubble_ex); // R9

   AST_NO_CODE_11: assert property (@(posedge clk) disable iff (!rst_n)
      ((fwd_sel & (fwd_sel >> 1)) & LOW_BITS) == '0); // R1

   AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_is_load |-> !hold_front); // R8

   AST_ZERO_DEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_dst_idx == '0) |-> !hold_front); // R5

   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_front |=> !hold_front); // R7

   AST_YOUNG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_use0 && mem_dst_wen && (mem_dst_idx != '0) && (ex_src0 == mem_dst_idx))
         |-> (fwd_sel[1:0] == 2'b10)); // R4
endmodule

bind hzd_fwd_unit hzd_fwd_chk #(.RW(RW), .NSRC(NSRC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ex_src0     (ex_src_idx[RW-1:0]),
   .ex_use0     (ex_src_use[0]),
   .ex_dst_idx  (ex_dst_idx),
   .ex_is_load  (ex_is_load),
   .mem_dst_idx (mem_dst_idx),
   .mem_dst_wen (mem_dst_wen),
   .fwd_sel     (fwd_sel),
   .hold_front  (hold_front),
   .bubble_ex   (bubble_ex)
);

// File: tb/hzd_fwd_unit_test.sv
module hzd_fwd_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int RW   = 5;
   localparam int NSRC = 2;

   typedef struct packed {
      logic [RW-1:0] rs1;
      logic [RW-1:0] rs2;
      logic          u1;
      logic          u2;
      logic [RW-1:0] rd;
      logic          wen;
      logic          ld;
   } ins_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC*RW-1:0] id_src_idx, ex_src_idx;
   logic [NSRC-1:0]    id_src_use, ex_src_use;
   logic [RW-1:0]      ex_dst_idx, mem_dst_idx, wb_dst_idx;
   logic               ex_dst_wen, ex_is_load, mem_dst_wen, wb_dst_wen;
   logic [2*NSRC-1:0]  fwd_sel;
   logic               hold_front, bubble_ex;

   int n_chk = 0;
   int n_bad = 0;

   ins_t s_id = '0, s_ex = '0, s_mem = '0, s_wb = '0;
   ins_t prog[$];
   logic st_d1 = 1'b0, st_d2 = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hzd_fwd_unit #(.RW(RW), .NSRC(NSRC)) uut (
      .clk(clk), .rst_n(rst_n),
      .id_src_idx(id_src_idx), .id_src_use(id_src_use),
      .ex_src_idx(ex_src_idx), .ex_src_use(ex_src_use),
      .ex_dst_idx(ex_dst_idx), .ex_dst_wen(ex_dst_wen), .ex_is_load(ex_is_load),
      .mem_dst_idx(mem_dst_idx), .mem_dst_wen(mem_dst_wen),
      .wb_dst_idx(wb_dst_idx), .wb_dst_wen(wb_dst_wen),
      .fwd_sel(fwd_sel), .hold_front(hold_front), .bubble_ex(bubble_ex)
   );

   function automatic ins_t mk(int a, int b, bit ua, bit ub, int d, bit w, bit l);
      ins_t t;
      t.rs1 = a[RW-1:0]; t.rs2 = b[RW-1:0];
      t.u1 = ua; t.u2 = ub;
      t.rd = d[RW-1:0]; t.wen = w; t.ld = l;
      return t;
   endfunction

   function automatic bit hit(logic [RW-1:0] s, logic u, ins_t p);
      return u && p.wen && (p.rd != 0) && (s == p.rd);
   endfunction

   function automatic int want_sel(logic [RW-1:0] s, logic u);
      if (hit(s, u, s_mem)) return 2;
      if (hit(s, u, s_wb))  return 1;
      return 0;
   endfunction

   function automatic string sel_tag(logic [RW-1:0] s, logic u);
      bit hm = hit(s, u, s_mem);
      bit hw = hit(s, u, s_wb);
      if (hm && hw) return "R4";
      if (hm)       return "R2";
      if (hw)       return st_d2 ? "R7" : "R3";
      return "R5";
   endfunction

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive();
      id_src_idx = {s_id.rs2, s_id.rs1};
      id_src_use = {s_id.u2, s_id.u1};
      ex_src_idx = {s_ex.rs2, s_ex.rs1};
      ex_src_use = {s_ex.u2, s_ex.u1};
      ex_dst_idx = s_ex.rd;  ex_dst_wen = s_ex.wen; ex_is_load = s_ex.ld;
      mem_dst_idx = s_mem.rd; mem_dst_wen = s_mem.wen;
      wb_dst_idx = s_wb.rd;  wb_dst_wen = s_wb.wen;
   endtask

   task automatic advance(input bit st);
      s_wb = s_mem;
      s_mem = s_ex;
      if (st) s_ex = '0;
      else begin
         s_ex = s_id;
         s_id = (prog.size() > 0) ? prog.pop_front() : '0;
      end
   endtask

   // one cycle of comparison against the model; returns the stall it expects
   task automatic check_cycle(output bit st);
      bit    dep_ex;
      string stag;
      st = s_ex.ld && (hit(s_id.rs1, s_id.u1, s_ex) || hit(s_id.rs2, s_id.u2, s_ex));
      dep_ex = hit(s_id.rs1, s_id.u1, s_ex) || hit(s_id.rs2, s_id.u2, s_ex);
      chk({"R1 ", sel_tag(s_ex.rs1, s_ex.u1)}, int'(fwd_sel[1:0]),
          want_sel(s_ex.rs1, s_ex.u1), "operand 0 select");
      chk({"R1 ", sel_tag(s_ex.rs2, s_ex.u2)}, int'(fwd_sel[3:2]),
          want_sel(s_ex.rs2, s_ex.u2), "operand 1 select");
      if (st)                      stag = "R6";
      else if (st_d1)              stag = "R7";
      else if (dep_ex && !s_ex.ld) stag = "R8";
      else                         stag = "R5";
      chk(stag, int'(hold_front), int'(st), "hold_front");
      chk("R9", int'(bubble_ex), int'(hold_front), "bubble_ex vs hold_front");
      st_d2 = st_d1;
      st_d1 = st;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit st;
      int len;
      drive();
      // dependent ALU pair (R2), then a non-load producer against decode (R8)
      prog.push_back(mk(1, 2, 1, 1, 3, 1, 0));
      prog.push_back(mk(3, 2, 1, 1, 4, 1, 0));
      // gap of one: write-back forwarding on operand 1 (R3)
      prog.push_back(mk(0, 0, 0, 0, 10, 1, 0));
      prog.push_back(mk(0, 0, 0, 0, 0, 0, 0));
      prog.push_back(mk(1, 10, 1, 1, 11, 1, 0));
      // both stages write 5 (R4)
      prog.push_back(mk(0, 0, 0, 0, 5, 1, 0));
      prog.push_back(mk(0, 0, 0, 0, 5, 1, 0));
      prog.push_back(mk(5, 5, 1, 1, 12, 1, 0));
      // load-use on operand 0 (R6, R7)
      prog.push_back(mk(1, 0, 1, 0, 6, 1, 1));
      prog.push_back(mk(6, 1, 1, 1, 13, 1, 0));
      // load with an unused matching source (R5)
      prog.push_back(mk(0, 0, 0, 0, 7, 1, 1));
      prog.push_back(mk(7, 7, 0, 0, 14, 1, 0));
      // load and ALU writing index 0 (R5)
      prog.push_back(mk(0, 0, 0, 0, 0, 1, 1));
      prog.push_back(mk(0, 0, 1, 1, 0, 1, 0));
      prog.push_back(mk(0, 0, 1, 1, 15, 1, 0));
      // write enable low (R5)
      prog.push_back(mk(0, 0, 0, 0, 8, 0, 1));
      prog.push_back(mk(8, 8, 1, 1, 16, 1, 0));
      // load-use on operand 1 (R6)
      prog.push_back(mk(0, 0, 0, 0, 9, 1, 1));
      prog.push_back(mk(2, 9, 1, 1, 17, 1, 0));
      prog.push_back(mk(9, 17, 1, 1, 18, 1, 0));
      for (int i = 0; i < 400; i++) begin
         prog.push_back(mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                           int'($urandom_range(0, 3)), $urandom_range(0, 3) != 0,
                           $urandom_range(0, 2) == 0));
      end
      len = prog.size();

      // R10: reset state with an empty pipeline
      for (int r = 0; r < 3; r++) begin
         @(negedge clk);
         chk("R10", int'(fwd_sel), 0, "select during reset");
         chk("R10", int'(hold_front), 0, "hold during reset");
      end
      rst_n = 1'b1;

      for (int c = 0; c < 2 * len + 10; c++) begin
         @(negedge clk);
         check_cycle(st);
         @(posedge clk);
         #1;
         advance(st);
         drive();
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule